// File: doc/BRIEF.md
# Three-Level Auxiliary Table Walker

This block turns a 48-bit main-surface virtual address into the address of its auxiliary data and the attributes of that surface. It does this by reading a three-level table out of memory. A lookup starts at a table base that the system supplies. The walker issues one 64-bit read per level through a request/response memory port. At each level it checks the entry's valid bit. For the two upper levels it forms the next table address from the entry. At the last level it unpacks the aux address together with the format, plane, bit-depth and tile-mode fields.

A lookup enters through a valid/ready handshake, and only one lookup is in flight at a time. When an entry at any level is not valid, the walk stops there. The result then carries a fault flag and a code that names the level where the walk stopped. The result is held on the output until the consumer takes it.

Top module: `auxtab_walker`

## Requirements
- R1: The top-level index is address bits 47:36, the middle index is bits 35:24 and the leaf index is bits 23:16. An entry is read at table base + 8 x index. Address bits 15:0 have no effect on any read or on the result.
- R2: Every read address is in canonical form: bits 63:48 of `mem_req_addr` equal bit 47.
- R3: In a top-level entry, bits 47:15 give the middle table address and its bits 14:0 are zero. Entry bits 14:1 and 63:48 are ignored.
- R4: In a middle-level entry, bits 47:13 give the leaf table address and its bits 12:0 are zero. Entry bits 12:1 and 63:48 are ignored.
- R5: A valid leaf entry is unpacked as follows. The aux address is entry bits 47:8 with the low 8 bits zero. The tile mode is bits 53:52, the depth code is bits 56:54, the plane is bit 57 (0 luma, 1 chroma) and the format is bits 63:58. Bits 7:1 and 51:48 are ignored.
- R6: Bit 0 of every entry is its valid bit. A clear bit ends the walk with no further read. The result then has `rsp_fault`=1 and `rsp_fault_level` set to 1 for the top level, 2 for the middle level or 3 for the leaf level, with all attribute fields zero. A walk that does not fault reports level code 0.
- R7: Reads are issued one at a time. No new request is made while a response is awaited. A walk makes exactly 3 reads when all levels are valid, or as many reads as the level that faulted.
- R8: A leaf tile mode of 2 or 3 is reserved and sets `rsp_tile_err`=1 without setting the fault. Tile modes 0 (Ys) and 1 (Y) leave `rsp_tile_err` clear.
- R9: `base_addr` is captured when a lookup is accepted. A change to it during a walk does not affect that walk.
- R10: `req_ready` is high only when no lookup is in flight. The result holds `rsp_valid` and all its fields stable until `rsp_ready` is seen.
- R11: Synchronous reset returns the walker to idle: `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_addr | input | 48 | Top-level table base, captured at lookup accept |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to accept a lookup |
| req_vaddr | input | 48 | Main-surface virtual address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Canonical byte address of the 64-bit entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_aux_addr | output | 48 | Aux-data address (low 8 bits zero) |
| rsp_format | output | 6 | Format code from the leaf entry |
| rsp_plane | output | 1 | Plane select: 0 luma, 1 chroma |
| rsp_depth | output | 3 | Bit-depth code |
| rsp_tile | output | 2 | Tile mode |
| rsp_fault | output | 1 | The walk met an invalid entry |
| rsp_fault_level | output | 2 | Level that faulted: 1 top, 2 middle, 3 leaf, 0 none |
| rsp_tile_err | output | 1 | Leaf tile mode is a reserved code |

## Verification
The bench fills the table entries with junk in every bit that should be ignored. A walker that masked the wrong alignment bits would therefore read from a wrong address and return a fault or the wrong fields. A memory model keyed by full 64-bit addresses catches a missing sign extension when a middle table sits above bit 47. That check also covers a leaf index taken from the wrong bit range, because such a walk lands on empty memory. Faults are placed at each of the three levels, and the bench counts the reads for each one. A walker that kept reading after an invalid entry, or that reported the wrong level code, fails there. The bench also changes the base input while a walk is in flight, and it holds back `rsp_ready` to expose a result that drifts before it is taken.

// File: rtl/auxtab_pkg.sv
package auxtab_pkg;

  localparam int VA_W       = 48;
  localparam int ENT_W      = 64;
  localparam int IDX_BASE   = 16;
  localparam int VA_HI_W    = VA_W - IDX_BASE;
  localparam int TOP_LSB    = 36;
  localparam int TOP_W      = 12;
  localparam int MID_LSB    = 24;
  localparam int MID_W      = 12;
  localparam int LEAF_LSB   = 16;
  localparam int LEAF_W     = 8;
  localparam int IDX_W      = (TOP_W > MID_W) ? TOP_W : MID_W;
  localparam int ENT_SHIFT  = 3;
  localparam int MID_ALIGN  = 15;
  localparam int LEAF_ALIGN = 13;
  localparam int PTR_W      = VA_W - LEAF_ALIGN;
  localparam int AUX_LSB    = 8;
  localparam int TILE_LSB   = 52;
  localparam int TILE_W     = 2;
  localparam int DEPTH_LSB  = 54;
  localparam int DEPTH_W    = 3;
  localparam int PLANE_BIT  = 57;
  localparam int FMT_LSB    = 58;
  localparam int FMT_W      = 6;

  localparam logic [1:0] LVL_TOP  = 2'd0;
  localparam logic [1:0] LVL_MID  = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } walk_st_t;

  typedef struct packed {
    logic [VA_W-1:0]    aux;
    logic [FMT_W-1:0]   fmt;
    logic               plane;
    logic [DEPTH_W-1:0] depth;
    logic [TILE_W-1:0]  tile;
  } leaf_t;

  // Index for the given level, taken from address bits above the page offset.
  function automatic logic [IDX_W-1:0] level_index(input logic [1:0] lvl,
                                                   input logic [VA_HI_W-1:0] va_hi);
    case (lvl)
      LVL_TOP: return IDX_W'(va_hi[TOP_LSB-IDX_BASE +: TOP_W]);
      LVL_MID: return IDX_W'(va_hi[MID_LSB-IDX_BASE +: MID_W]);
      default: return IDX_W'(va_hi[LEAF_LSB-IDX_BASE +: LEAF_W]);
    endcase
  endfunction

  // Byte address of an 8-byte entry within a table.
  function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
    return tbl + (VA_W'(idx) << ENT_SHIFT);
  endfunction

  // Sign-extend bit 47 into the upper bits.
  function automatic logic [ENT_W-1:0] canon(input logic [VA_W-1:0] a);
    return {{(ENT_W-VA_W){a[VA_W-1]}}, a};
  endfunction

  // Next table base from entry bits 47:13; the top level drops two more bits.
  function automatic logic [VA_W-1:0] next_table(input logic [1:0] lvl,
                                                 input logic [PTR_W-1:0] ptr);
    if (lvl == LVL_TOP)
      return {ptr[PTR_W-1:MID_ALIGN-LEAF_ALIGN], MID_ALIGN'(0)};
    else
      return {ptr, LEAF_ALIGN'(0)};
  endfunction

endpackage

// File: rtl/auxtab_addr_gen.sv
module auxtab_addr_gen
  import auxtab_pkg::*;
(
  input  logic [VA_W-1:0]    tbl,
  input  logic [1:0]         lvl,
  input  logic [VA_HI_W-1:0] va_hi,
  output logic [ENT_W-1:0]   req_addr
);
  logic [IDX_W-1:0] idx;
  logic [VA_W-1:0]  raw_addr;

  assign idx      = level_index(lvl, va_hi);
  assign raw_addr = entry_addr(tbl, idx);
  assign req_addr = canon(raw_addr);
endmodule

// File: rtl/auxtab_leaf_unpack.sv
module auxtab_leaf_unpack
  import auxtab_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  output leaf_t            leaf,
  output logic             tile_rsvd
);
  logic unused_fields;

  assign leaf.aux   = {entry[VA_W-1:AUX_LSB], AUX_LSB'(0)};
  assign leaf.tile  = entry[TILE_LSB +: TILE_W];
  assign leaf.depth = entry[DEPTH_LSB +: DEPTH_W];
  assign leaf.plane = entry[PLANE_BIT];
  assign leaf.fmt   = entry[FMT_LSB +: FMT_W];
  // codes 2 and 3 are reserved tile modes
  assign tile_rsvd  = (leaf.tile >= TILE_W'(2));
  assign unused_fields = ^{entry[AUX_LSB-1:0], entry[TILE_LSB-1:VA_W]};
endmodule

// File: rtl/auxtab_walker.sv
module auxtab_walker
  import auxtab_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [VA_W-1:0]    base_addr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ENT_W-1:0]   mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_aux_addr,
  output logic [FMT_W-1:0]   rsp_format,
  output logic               rsp_plane,
  output logic [DEPTH_W-1:0] rsp_depth,
  output logic [TILE_W-1:0]  rsp_tile,
  output logic               rsp_fault,
  output logic [1:0]         rsp_fault_level,
  output logic               rsp_tile_err
);
  walk_st_t           st;
  logic [1:0]         lvl;
  logic [VA_HI_W-1:0] va_q;
  logic [VA_W-1:0]    tbl_q;
  leaf_t              res_leaf;
  logic               res_fault;
  logic [1:0]         res_flvl;
  logic               res_terr;

  leaf_t              leaf_d;
  logic               tile_rsvd_d;
  logic               unused_va_lo;

  // named events for the checker
  logic walk_accept;
  logic mem_fire;
  logic walk_waiting;
  logic entry_back;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign rsp_valid     = (st == ST_RESP);
  assign walk_waiting  = (st == ST_WAIT);
  assign walk_accept   = req_valid && req_ready;
  assign mem_fire      = mem_req_valid && mem_req_ready;
  assign entry_back    = walk_waiting && mem_rsp_valid;
  assign unused_va_lo  = ^req_vaddr[IDX_BASE-1:0];

  auxtab_addr_gen u_addr (
    .tbl      (tbl_q),
    .lvl      (lvl),
    .va_hi    (va_q),
    .req_addr (mem_req_addr)
  );

  auxtab_leaf_unpack u_leaf (
    .entry     (mem_rsp_data),
    .leaf      (leaf_d),
    .tile_rsvd (tile_rsvd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      lvl       <= LVL_TOP;
      va_q      <= '0;
      tbl_q     <= '0;
      res_leaf  <= '0;
      res_fault <= 1'b0;
      res_flvl  <= 2'd0;
      res_terr  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (walk_accept) begin
            va_q      <= req_vaddr[VA_W-1:IDX_BASE];
            tbl_q     <= base_addr;
            lvl       <= LVL_TOP;
            res_leaf  <= '0;
            res_fault <= 1'b0;
            res_flvl  <= 2'd0;
            res_terr  <= 1'b0;
            st        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_fire) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (entry_back) begin
            if (!mem_rsp_data[0]) begin
              res_fault <= 1'b1;
              res_flvl  <= 2'(lvl + 2'd1);
              st        <= ST_RESP;
            end else if (lvl == LVL_LEAF) begin
              res_leaf <= leaf_d;
              res_terr <= tile_rsvd_d;
              st       <= ST_RESP;
            end else begin
              tbl_q <= next_table(lvl, mem_rsp_data[VA_W-1:LEAF_ALIGN]);
              lvl   <= 2'(lvl + 2'd1);
              st    <= ST_REQ;
            end
          end
        end
        default: begin
          if (rsp_ready) st <= ST_IDLE;
        end
      endcase
    end
  end

  assign rsp_aux_addr    = res_leaf.aux;
  assign rsp_format      = res_leaf.fmt;
  assign rsp_plane       = res_leaf.plane;
  assign rsp_depth       = res_leaf.depth;
  assign rsp_tile        = res_leaf.tile;
  assign rsp_fault       = res_fault;
  assign rsp_fault_level = res_flvl;
  assign rsp_tile_err    = res_terr;
endmodule

// File: rtl/auxtab_walker_chk.sv
module auxtab_walker_chk
  import auxtab_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ENT_W-1:0]   mem_req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [VA_W-1:0]    rsp_aux_addr,
  input logic [FMT_W-1:0]   rsp_format,
  input logic [TILE_W-1:0]  rsp_tile,
  input logic               rsp_fault,
  input logic [1:0]         rsp_fault_level,
  input logic               rsp_tile_err,
  input logic               walk_accept,
  input logic               mem_fire,
  input logic               walk_waiting
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst || walk_accept) rd_cnt <= 2'd0;
    else if (mem_fire)      rd_cnt <= 2'(rd_cnt + 2'd1);
  end

  a_r2_canonical_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[ENT_W-1:VA_W] == {(ENT_W-VA_W){mem_req_addr[VA_W-1]}}));

  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r7_single_read: assert property (@(posedge clk) disable iff (rst)
    walk_waiting |-> !mem_req_valid);

  a_r7_at_most_three: assert property (@(posedge clk) disable iff (rst)
    mem_fire |-> (rd_cnt != 2'd3));

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_aux_addr, rsp_format, rsp_tile, rsp_fault, rsp_fault_level, rsp_tile_err}));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    walk_accept |=> !req_ready);

  a_r10_idle_exclusive: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid && !mem_req_valid);

  a_r6_level_code: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_fault_level != 2'd0)));

  a_r6_fault_clears: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> (rsp_aux_addr == '0) && !rsp_tile_err);

  a_r8_tile_flag: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_tile_err |-> rsp_tile[1]);

  a_r5_aux_aligned: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_aux_addr[AUX_LSB-1:0] == '0));
endmodule

bind auxtab_walker auxtab_walker_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_ready       (req_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_aux_addr    (rsp_aux_addr),
  .rsp_format      (rsp_format),
  .rsp_tile        (rsp_tile),
  .rsp_fault       (rsp_fault),
  .rsp_fault_level (rsp_fault_level),
  .rsp_tile_err    (rsp_tile_err),
  .walk_accept     (walk_accept),
  .mem_fire        (mem_fire),
  .walk_waiting    (walk_waiting)
);

// File: tb/auxtab_walker_bench.sv
module auxtab_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] base_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [47:0] rsp_aux_addr;
  logic [5:0]  rsp_format;
  logic        rsp_plane;
  logic [2:0]  rsp_depth;
  logic [1:0]  rsp_tile;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_level;
  logic        rsp_tile_err;

  always #2 clk = ~clk;

  auxtab_walker u_auxtab_walker (.*);

  typedef struct {
    logic [47:0] aux;
    logic [5:0]  fmt;
    logic        plane;
    logic [2:0]  depth;
    logic [1:0]  tile;
    logic        fault;
    logic [1:0]  flvl;
    logic        terr;
    int          nreads;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  logic [63:0] mem [logic [63:0]];
  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int rd_total = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [47:0] a);
    return {{16{a[47]}}, a};
  endfunction

  function automatic logic [63:0] memget(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  task automatic put(input logic [47:0] a, input logic [63:0] d);
    mem[sx(a)] = d;
  endtask

  function automatic logic [63:0] mk_tbl(input logic [47:0] nxt, input logic [63:0] junk);
    return {16'hBEEF, nxt} | junk | 64'd1;
  endfunction

  function automatic logic [63:0] mk_leaf(input logic [5:0] f, input logic p, input logic [2:0] d,
                                          input logic [1:0] t, input logic [47:0] aux);
    return {f, p, d, t, 4'hA, aux[47:8], 7'h55, 1'b1};
  endfunction

  // independent walk over the bench memory, following the requirements
  function automatic exp_t ref_walk(input logic [47:0] base, input logic [47:0] va);
    exp_t e;
    logic [63:0] tbl, a, d;
    int sh;
    logic [63:0] msk;
    e = '{aux:'0, fmt:'0, plane:1'b0, depth:'0, tile:'0, fault:1'b0, flvl:2'd0, terr:1'b0, nreads:0};
    tbl = sx(base);
    for (int l = 0; l < 3; l++) begin
      sh  = (l == 0) ? 36 : (l == 1) ? 24 : 16;
      msk = (l == 2) ? 64'hFF : 64'hFFF;
      a = tbl + (((64'(va) >> sh) & msk) * 8);
      d = memget(a);
      e.nreads++;
      if (d[0] == 1'b0) begin
        e.fault = 1'b1;
        e.flvl  = 2'(l + 1);
        return e;
      end
      if (l == 0)      tbl = sx(d[47:0] & 48'hFFFF_FFFF_8000);
      else if (l == 1) tbl = sx(d[47:0] & 48'hFFFF_FFFF_E000);
      else begin
        e.aux   = d[47:0] & 48'hFFFF_FFFF_FF00;
        e.tile  = d[53:52];
        e.depth = d[56:54];
        e.plane = d[57];
        e.fmt   = d[63:58];
        e.terr  = (d[53:52] > 2'd1);
      end
    end
    return e;
  endfunction

  // driver: push expectation, then perform the request handshake
  task automatic lookup(input logic [47:0] base, input logic [47:0] va,
                        input bit change_base, input string tag);
    exp_q.push_back(ref_walk(base, va));
    tag_q.push_back(tag);
    @(negedge clk);
    base_addr = base;
    req_vaddr = va;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (change_base) base_addr = 48'h0000_0090_0000;
    chk({tag, " R10 busy after accept"}, 64'(req_ready), 64'd0);
  endtask

  // memory responder with varying latency
  initial begin
    logic [63:0] a;
    int lat;
    forever begin
      if (mem_req_valid === 1'b1) begin
        a = mem_req_addr;
        rd_count++;
        rd_total++;
        lat = 1 + (rd_total % 3);
        @(negedge clk);
        repeat (lat - 1) @(negedge clk);
        mem_rsp_data  = memget(a);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 64'hDEAD_DEAD_DEAD_DEAD;
      end else begin
        @(negedge clk);
      end
    end
  end

  // monitor: hold the result one extra cycle, then compare and take it
  initial begin
    int hold = 0;
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      rsp_ready = 1'b0;
      if (rsp_valid === 1'b1) begin
        if (hold < 1) hold++;
        else begin
          hold = 0;
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10 unexpected result actual=1 expected=0");
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " R5 aux"},          64'(rsp_aux_addr), 64'(e.aux));
            chk({t, " R5 format"},       64'(rsp_format),   64'(e.fmt));
            chk({t, " R5 plane"},        64'(rsp_plane),    64'(e.plane));
            chk({t, " R5 depth"},        64'(rsp_depth),    64'(e.depth));
            chk({t, " R5 tile"},         64'(rsp_tile),     64'(e.tile));
            chk({t, " R6 fault"},        64'(rsp_fault),    64'(e.fault));
            chk({t, " R6 level"},        64'(rsp_fault_level), 64'(e.flvl));
            chk({t, " R8 tile_err"},     64'(rsp_tile_err), 64'(e.terr));
            chk({t, " R7 read count"},   64'(rd_count),     64'(e.nreads));
          end
          rd_count = 0;
          rsp_ready = 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [47:0] T  = 48'h0000_0010_0000;
  localparam logic [47:0] M  = 48'h0000_0020_8000;
  localparam logic [47:0] L  = 48'h0000_0031_2000;
  localparam logic [47:0] M2 = 48'h8000_0040_0000;
  localparam logic [47:0] L2 = 48'h0000_0050_0000;

  initial begin
    // table contents; junk in every ignored bit (R3, R4, R5)
    put(T + 48'h123 * 8, mk_tbl(M, 64'h7FFE));
    put(M + 48'h456 * 8, mk_tbl(L, 64'h1FFE));
    put(L + 48'h78 * 8, mk_leaf(6'h2B, 1'b1, 3'd5, 2'd1, 48'h0000_7777_AB00));
    put(L + 48'h7A * 8, mk_leaf(6'h01, 1'b0, 3'd2, 2'd2, 48'h0000_1111_0000));
    put(L + 48'h7B * 8, mk_leaf(6'h02, 1'b1, 3'd3, 2'd3, 48'h0000_2222_0100));
    put(L + 48'h7C * 8, mk_leaf(6'h03, 1'b0, 3'd4, 2'd0, 48'h0000_3333_0200));
    put(L + 48'h7D * 8, 64'hFFFF_FFFF_FFFF_FFFE);
    // middle table above bit 47 (R2 canonical)
    put(T + 48'h800 * 8, mk_tbl(M2, 64'h0));
    put(M2 + 48'h001 * 8, mk_tbl(L2, 64'h0));
    put(L2 + 48'h02 * 8, mk_leaf(6'h3F, 1'b0, 3'd7, 2'd0, 48'hFFFF_FFFF_FF00));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 req_ready after reset",     64'(req_ready),     64'd1);
    chk("R11 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk("R11 rsp_valid after reset",     64'(rsp_valid),     64'd0);

    lookup(T, 48'h1234_5678_9ABC, 0, "R3/R4 junk full walk");
    lookup(T, 48'h1234_5678_0000, 0, "R1 offset bits ignored");
    lookup(T, 48'h1240_0000_0000, 0, "R6 top fault");
    lookup(T, 48'h1234_5700_0000, 0, "R6 middle fault");
    lookup(T, 48'h1234_5679_0000, 0, "R6 leaf fault");
    lookup(T, 48'h1234_567D_0000, 0, "R6 leaf invalid with junk");
    lookup(T, 48'h1234_567A_0000, 0, "R8 tile code 2");
    lookup(T, 48'h1234_567B_FFFF, 0, "R8 tile code 3");
    lookup(T, 48'h1234_567C_0000, 0, "R8 tile code 0");
    lookup(T, 48'h8000_0102_0000, 0, "R2 canonical middle table");
    lookup(T, 48'h1234_5678_1234, 1, "R9 base changed mid-walk");
    lookup(48'h0000_0090_0000, 48'h1234_5678_0000, 0, "R9 new base used");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 idle at end", 64'(req_ready), 64'd1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule